// File: doc/BRIEF.md
# Dual-Channel Phase Detector with Lock Detect

This block holds two independent phase-frequency detectors. Each one compares a reference pulse train (fr) with a divided feedback pulse train (fp). It produces a three-state control for an external charge pump: drive high, drive low, or release the line (high impedance). The detectors run in the reference-oscillator clock domain. The phase error of every comparison is measured as a whole number of oscillator clocks, and the count saturates at 15.

A digital lock detector in each channel watches these error measurements. A channel is declared locked after a run of small errors and drops out of lock on a single large error. The lock states of the two channels are ANDed into one combined lock signal, and a channel in power-save counts as locked. A monitor multiplexer drives one shared pin. The pin carries either the combined lock signal or one of the four raw pulse trains, chosen by a select bit and a 2-bit selector.

Each channel has its own power-save input. While a channel is powered down, its output is released and its lock state is cleared. On return to normal operation, the first comparison's correction pulse is held to one oscillator period, so the loop does not take a large kick when it starts up again.

Top module: `dual_phase_lock_det`

## Requirements
- R1: With fc_i = 1 for a channel, a rising fr edge k clocks (k ≥ 1) ahead of the rising fp edge gives drv_oe_o = 1 with drv_hi_o = 1 for exactly k clocks. An fp edge k clocks ahead of fr gives drv_hi_o = 0 for k clocks.
- R2: With fc_i = 0, the polarity of R1 is reversed: fr ahead drives drv_hi_o = 0, and fp ahead drives drv_hi_o = 1. Pulse lengths are the same as in R1.
- R3: Rising fr and fp edges detected in the same clock give no drive pulse (drv_oe_o stays 0) and are measured as an error of 0.
- R4: A one-clock error still gives a one-clock drive pulse while the channel is locked (no dead zone), and it does not drop the lock.
- R5: A channel becomes locked only after three consecutive measurements with an error of at most 1 clock. Two such measurements are not enough.
- R6: A single measurement with an error of 2 clocks or more clears the channel's lock. Errors saturate at 15.
- R7: With lds_i = 0, mon_o = 1 exactly when each channel is either locked or powered down (pwr_on_i bit = 0). After reset with both channels powered down, mon_o = 1.
- R8: With lds_i = 1, mon_o follows a raw input selected by {t2_i,t1_i}: 00 → fr_i[0], 01 → fr_i[1], 10 → fp_i[0], 11 → fp_i[1].
- R9: While pwr_on_i[c] = 0, drv_oe_o[c] = 0 whatever the inputs are. A channel returns from power-save unlocked.
- R10: The first comparison after a channel leaves power-save (or after reset) drives for at most one clock, whatever its error. Later comparisons drive for their full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fr_i | input | 2 | Reference pulse train per channel (bit 0 = channel A) |
| fp_i | input | 2 | Divided feedback pulse train per channel |
| fc_i | input | 2 | Drive polarity per channel |
| pwr_on_i | input | 2 | 1 = normal operation, 0 = power-save, per channel |
| lds_i | input | 1 | Monitor source: 0 = combined lock, 1 = raw pulse train |
| t1_i | input | 1 | Monitor selector, low bit |
| t2_i | input | 1 | Monitor selector, high bit |
| drv_hi_o | output | 2 | Drive level per channel when enabled |
| drv_oe_o | output | 2 | Drive enable per channel; 0 = high impedance |
| mon_o | output | 1 | Shared monitor pin |

## Verification
A table of comparisons tries every combination of polarity bit and leading input, with gaps of 0 to 3 clocks. This separates the pulse-length measurement from the polarity swap and from the aligned case. Sequences of one-clock, aligned and two-clock errors are sent to find where lock is gained and lost. They show that the third good measurement sets lock, not the second, and that one bad measurement clears it. Power-save is switched on and off while edges keep arriving, which shows the release of the drive, the clearing of lock, and the one-clock limit on the first pulse afterwards. Static levels on the four raw inputs, chosen so that each selector value gives a different answer, show the monitor mapping.

// File: rtl/dpl_pkg.sv
package dpl_pkg;
  typedef enum logic [1:0] {
    MON_FR_A = 2'd0,
    MON_FR_B = 2'd1,
    MON_FP_A = 2'd2,
    MON_FP_B = 2'd3
  } mon_sel_e;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/dpl_pfd.sv
module dpl_pfd #(
  parameter int ERR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_on_i,
  input  logic             fc_i,
  input  logic             fr_i,
  input  logic             fp_i,
  output logic             drv_hi_o,
  output logic             drv_oe_o,
  output logic             up_o,
  output logic             meas_v_o,
  output logic [ERR_W-1:0] meas_err_o
);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};
  localparam logic [ERR_W-1:0] ONE     = ERR_W'(1);

  logic fr_q, fp_q, rise_r, rise_p;
  logic up_q, dn_q, first_q;
  logic [ERR_W-1:0] cnt_q;

  assign rise_r = fr_i & ~fr_q;
  assign rise_p = fp_i & ~fp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fr_q <= 1'b0;
      fp_q <= 1'b0;
    end else begin
      fr_q <= fr_i;
      fp_q <= fp_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q       <= 1'b0;
      dn_q       <= 1'b0;
      cnt_q      <= '0;
      first_q    <= 1'b1;
      meas_v_o   <= 1'b0;
      meas_err_o <= '0;
    end else if (!pwr_on_i) begin
      up_q     <= 1'b0;
      dn_q     <= 1'b0;
      cnt_q    <= '0;
      first_q  <= 1'b1;
      meas_v_o <= 1'b0;
    end else begin
      meas_v_o <= 1'b0;
      if (!up_q && !dn_q) begin
        if (rise_r && rise_p) begin
          meas_v_o   <= 1'b1;
          meas_err_o <= '0;
          first_q    <= 1'b0;
        end else if (rise_r) begin
          up_q  <= 1'b1;
          cnt_q <= ONE;
        end else if (rise_p) begin
          dn_q  <= 1'b1;
          cnt_q <= ONE;
        end
      end else if ((up_q && rise_p) || (dn_q && rise_r)) begin
        meas_v_o   <= 1'b1;
        meas_err_o <= cnt_q;
        first_q    <= 1'b0;
        // a fresh leading edge in the closing cycle opens the next window
        up_q  <= up_q & rise_r;
        dn_q  <= dn_q & rise_p;
        cnt_q <= ONE;
      end else if (cnt_q != ERR_MAX) begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign up_o     = up_q;
  assign drv_oe_o = pwr_on_i & (up_q | dn_q) & (~first_q | (cnt_q == ONE));
  assign drv_hi_o = up_q ? fc_i : ~fc_i;
endmodule

// File: rtl/dpl_lock_det.sv
module dpl_lock_det #(
  parameter int ERR_W      = 4,
  parameter int LOCK_ERR   = 1,
  parameter int UNLOCK_ERR = 2,
  parameter int LOCK_RUN   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_on_i,
  input  logic             meas_v_i,
  input  logic [ERR_W-1:0] meas_err_i,
  output logic             locked_o
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_TGT = RUN_W'(LOCK_RUN);
  localparam logic [ERR_W-1:0] ERR_OK  = ERR_W'(LOCK_ERR);
  localparam logic [ERR_W-1:0] ERR_BAD = ERR_W'(UNLOCK_ERR);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= '0;
      locked_o <= 1'b0;
    end else if (!pwr_on_i) begin
      run_q    <= '0;
      locked_o <= 1'b0;
    end else if (meas_v_i) begin
      if (meas_err_i >= ERR_BAD) begin
        run_q    <= '0;
        locked_o <= 1'b0;
      end else if (meas_err_i <= ERR_OK) begin
        if (run_q != RUN_TGT) run_q <= run_q + 1'b1;
        if (run_q + 1'b1 >= RUN_TGT) locked_o <= 1'b1;
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/dpl_mon_mux.sv
module dpl_mon_mux
  import dpl_pkg::*;
(
  input  logic                 lds_i,
  input  mon_sel_e             sel_i,
  input  logic [NUM_CH-1:0]    ch_ok_i,
  input  logic [NUM_CH-1:0]    fr_i,
  input  logic [NUM_CH-1:0]    fp_i,
  output logic                 mon_o
);
  logic raw;

  always_comb begin
    unique case (sel_i)
      MON_FR_A: raw = fr_i[0];
      MON_FR_B: raw = fr_i[1];
      MON_FP_A: raw = fp_i[0];
      default:  raw = fp_i[1];
    endcase
  end

  assign mon_o = lds_i ? raw : &ch_ok_i;
endmodule

// File: rtl/dual_phase_lock_det.sv
module dual_phase_lock_det
  import dpl_pkg::*;
#(
  parameter int ERR_W      = 4,
  parameter int LOCK_ERR   = 1,
  parameter int UNLOCK_ERR = 2,
  parameter int LOCK_RUN   = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] fr_i,
  input  logic [1:0] fp_i,
  input  logic [1:0] fc_i,
  input  logic [1:0] pwr_on_i,
  input  logic       lds_i,
  input  logic       t1_i,
  input  logic       t2_i,
  output logic [1:0] drv_hi_o,
  output logic [1:0] drv_oe_o,
  output logic       mon_o
);
  logic [NUM_CH-1:0]            up_w;
  logic [NUM_CH-1:0]            meas_v_w;
  logic [NUM_CH-1:0][ERR_W-1:0] meas_err_w;
  logic [NUM_CH-1:0]            locked_w;
  logic [NUM_CH-1:0]            ch_ok_w;
  mon_sel_e                     sel_w;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dpl_pfd #(.ERR_W(ERR_W)) u_pfd (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pwr_on_i   (pwr_on_i[c]),
      .fc_i       (fc_i[c]),
      .fr_i       (fr_i[c]),
      .fp_i       (fp_i[c]),
      .drv_hi_o   (drv_hi_o[c]),
      .drv_oe_o   (drv_oe_o[c]),
      .up_o       (up_w[c]),
      .meas_v_o   (meas_v_w[c]),
      .meas_err_o (meas_err_w[c])
    );

    dpl_lock_det #(
      .ERR_W(ERR_W), .LOCK_ERR(LOCK_ERR),
      .UNLOCK_ERR(UNLOCK_ERR), .LOCK_RUN(LOCK_RUN)
    ) u_lock (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pwr_on_i   (pwr_on_i[c]),
      .meas_v_i   (meas_v_w[c]),
      .meas_err_i (meas_err_w[c]),
      .locked_o   (locked_w[c])
    );

    assign ch_ok_w[c] = locked_w[c] | ~pwr_on_i[c];
  end

  assign sel_w = mon_sel_e'({t2_i, t1_i});

  dpl_mon_mux u_mux (
    .lds_i   (lds_i),
    .sel_i   (sel_w),
    .ch_ok_i (ch_ok_w),
    .fr_i    (fr_i),
    .fp_i    (fp_i),
    .mon_o   (mon_o)
  );
endmodule

// File: rtl/dpl_checker.sv
module dpl_checker #(
  parameter int ERR_W      = 4,
  parameter int LOCK_ERR   = 1,
  parameter int UNLOCK_ERR = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [1:0]            fr_i,
  input logic [1:0]            fp_i,
  input logic [1:0]            fc_i,
  input logic [1:0]            pwr_on_i,
  input logic                  lds_i,
  input logic                  t1_i,
  input logic                  t2_i,
  input logic [1:0]            drv_hi_o,
  input logic [1:0]            drv_oe_o,
  input logic                  mon_o,
  input logic [1:0]            up_w,
  input logic [1:0]            meas_v_w,
  input logic [1:0][ERR_W-1:0] meas_err_w,
  input logic [1:0]            locked_w
);
  for (genvar c = 0; c < 2; c++) begin : g_chk
    p_save_hiz_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwr_on_i[c] |-> !drv_oe_o[c]);

    p_drive_pol_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drv_oe_o[c] && up_w[c]) |-> (drv_hi_o[c] == fc_i[c]));

    p_unlock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (meas_v_w[c] && meas_err_w[c] >= ERR_W'(UNLOCK_ERR)) |=> !locked_w[c]);

    p_lock_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(locked_w[c]) |-> ($past(meas_v_w[c]) && $past(meas_err_w[c]) <= ERR_W'(LOCK_ERR)));
  end

  p_mon_fra_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lds_i && !t1_i && !t2_i) |-> (mon_o == fr_i[0]));

  p_mon_fpb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lds_i && t1_i && t2_i) |-> (mon_o == fp_i[1]));

  p_mon_save_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lds_i && pwr_on_i == 2'b00) |-> mon_o);
endmodule

bind dual_phase_lock_det dpl_checker #(
  .ERR_W(ERR_W), .LOCK_ERR(LOCK_ERR), .UNLOCK_ERR(UNLOCK_ERR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fr_i       (fr_i),
  .fp_i       (fp_i),
  .fc_i       (fc_i),
  .pwr_on_i   (pwr_on_i),
  .lds_i      (lds_i),
  .t1_i       (t1_i),
  .t2_i       (t2_i),
  .drv_hi_o   (drv_hi_o),
  .drv_oe_o   (drv_oe_o),
  .mon_o      (mon_o),
  .up_w       (up_w),
  .meas_v_w   (meas_v_w),
  .meas_err_w (meas_err_w),
  .locked_w   (locked_w)
);

// File: tb/dual_phase_lock_det_test.sv
`timescale 1ns/1ps
module dual_phase_lock_det_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] fr = '0, fp = '0, fc = '0, pwr = '0;
  logic       lds = 1'b0, t1 = 1'b0, t2 = 1'b0;
  logic [1:0] hi, oe;
  logic       mon;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_phase_lock_det uut (
    .clk_i(clk), .rst_ni(rst_n), .fr_i(fr), .fp_i(fp), .fc_i(fc),
    .pwr_on_i(pwr), .lds_i(lds), .t1_i(t1), .t2_i(t2),
    .drv_hi_o(hi), .drv_oe_o(oe), .mon_o(mon)
  );

  // fc, fr_leads, gap, expected drive level
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{1, 1, 3, 1}, '{1, 0, 3, 0}, '{0, 1, 2, 0}, '{0, 0, 2, 1},
    '{1, 1, 0, 1}, '{1, 1, 1, 1}, '{0, 0, 1, 1}, '{1, 0, 2, 0}
  };

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one comparison on channel ch; returns enabled-drive cycles and wrong-level samples
  task automatic cmp(input int ch, input int fr_lead, input int gap, input int exp_hi,
                     output int n_oe, output int n_bad);
    n_oe = 0; n_bad = 0;
    @(negedge clk);
    if (fr_lead != 0 || gap == 0) fr[ch] = 1'b1;
    if (fr_lead == 0 || gap == 0) fp[ch] = 1'b1;
    for (int i = 1; i <= gap + 3; i++) begin
      @(negedge clk);
      if (oe[ch]) begin
        n_oe++;
        if (int'(hi[ch]) != exp_hi) n_bad++;
      end
      if (i == gap) begin fr[ch] = 1'b1; fp[ch] = 1'b1; end
    end
    fr[ch] = 1'b0; fp[ch] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(mon, 1, "R7 reset both powered down mon");
    check(oe, 0, "R9 reset drive released");

    pwr = 2'b01;
    @(negedge clk);
    check(mon, 0, "R7 channel A on and unlocked");
    cmp(0, 1, 5, 0, n, b);
    check(n, 1, "R10 first pulse after power-up limited");

    fc[0] = 1'b1;
    for (int v = 0; v < NV; v++) begin
      fc[0] = VEC[v][0][0];
      cmp(0, VEC[v][1], VEC[v][2], VEC[v][3], n, b);
      check(n, VEC[v][2], $sformatf("R1 R2 R3 vec%0d pulse length", v));
      check(b, 0, $sformatf("R1 R2 vec%0d drive level", v));
    end

    fc[0] = 1'b1;
    cmp(0, 1, 4, 1, n, b);
    check(mon, 0, "R6 large error clears lock");
    cmp(0, 1, 1, 1, n, b);
    cmp(0, 0, 1, 0, n, b);
    check(mon, 0, "R5 two good measurements not enough");
    cmp(0, 1, 1, 1, n, b);
    check(mon, 1, "R5 third good measurement locks");
    cmp(0, 0, 1, 0, n, b);
    check(n, 1, "R4 one-clock pulse while locked");
    check(mon, 1, "R4 lock kept on one-clock error");
    cmp(0, 1, 2, 1, n, b);
    check(mon, 0, "R6 two-clock error drops lock");
    cmp(0, 1, 0, 1, n, b);
    cmp(0, 1, 0, 1, n, b);
    cmp(0, 1, 0, 1, n, b);
    check(mon, 1, "R5 R3 aligned edges relock");
    cmp(0, 1, 20, 1, n, b);
    check(n, 20, "R6 long pulse past saturation");
    check(mon, 0, "R6 saturated error unlocks");
    repeat (3) cmp(0, 1, 0, 1, n, b);

    pwr = 2'b11;
    @(negedge clk);
    check(mon, 0, "R7 channel B on unlocked");
    fc[1] = 1'b0;
    repeat (3) cmp(1, 0, 0, 1, n, b);
    check(mon, 1, "R7 both locked");

    pwr[0] = 1'b0;
    cmp(0, 1, 3, 1, n, b);
    check(n, 0, "R9 no drive in power-save");
    check(mon, 1, "R7 powered-down channel counts as locked");
    pwr[0] = 1'b1;
    @(negedge clk);
    check(mon, 0, "R9 lock cleared by power-save");
    cmp(0, 1, 4, 1, n, b);
    check(n, 1, "R10 first pulse limited after power-save");
    cmp(0, 1, 4, 1, n, b);
    check(n, 4, "R10 later pulse full length");

    lds = 1'b1;
    fr = 2'b01; fp = 2'b10;
    {t2, t1} = 2'b00; #1 check(mon, 1, "R8 sel 00 fr A");
    {t2, t1} = 2'b01; #1 check(mon, 0, "R8 sel 01 fr B");
    {t2, t1} = 2'b10; #1 check(mon, 0, "R8 sel 10 fp A");
    {t2, t1} = 2'b11; #1 check(mon, 1, "R8 sel 11 fp B");
    fr = 2'b10; fp = 2'b01;
    {t2, t1} = 2'b00; #1 check(mon, 0, "R8 sel 00 fr A swap");
    {t2, t1} = 2'b01; #1 check(mon, 1, "R8 sel 01 fr B swap");
    {t2, t1} = 2'b10; #1 check(mon, 1, "R8 sel 10 fp A swap");
    {t2, t1} = 2'b11; #1 check(mon, 0, "R8 sel 11 fp B swap");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule